// File: doc/BRIEF.md
# Phase Offset Recalibration Sequencer

This block owns the phase offset that is applied to a clock path. It never lets that offset jump. Whenever the programmed target changes, the applied value walks toward the new target in bounded steps. Each step is at most `STEP` counts, and one step happens at most every `STEP_DIV` clock cycles. Because of this, downstream phase movement stays slow enough for the loop to absorb.

Software can also set a start bit. This launches a recalibration that is hidden from the outputs. The sequence runs in this order:

1. The clock path is placed in holdover.
2. The applied offset is walked down to zero.
3. A one-cycle reset is pulsed to every output and feedback divider.
4. The offset is walked back up to the target.
5. Holdover is released.

The `busy` output is the readback of the start bit. It clears by itself when holdover is released.

A target written while the sequence runs is captured, and the final ramp uses it. A start request that arrives while the sequence is already running has no effect.

Top module: `phofs_recal_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `applied_ofs` is 0 and `holdover`, `div_rst` and `busy` are all 0. This also holds when reset arrives in the middle of a sequence.
- R2: Each change of `applied_ofs` has a magnitude of at most `STEP`, and two changes are at least `STEP_DIV` cycles apart. With `busy` low, `applied_ofs` settles on `target_ofs` within ceil(|difference|/`STEP`)·`STEP_DIV` plus a few cycles.
- R3: When `cal_req` is high in a cycle where `busy` is low, `busy` and `holdover` are both 1 in the next cycle.
- R4: During a sequence, the magnitude of `applied_ofs` never grows before the divider reset. `div_rst` is asserted only while `applied_ofs` equals 0 and `holdover` is 1.
- R5: Each sequence produces exactly one `div_rst` pulse, and that pulse is one cycle long.
- R6: `busy` and `holdover` fall together. When they fall, `applied_ofs` equals the latched target.
- R7: If `target_ofs` changes while `busy` is high, the final ramp ends at the new value.
- R8: A `cal_req` that arrives while `busy` is high is ignored. It adds no extra divider pulse and does not restart the sequence after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Write of 1 to the start bit |
| target_ofs | input | OFS_W | Programmed signed phase offset |
| applied_ofs | output | OFS_W | Signed offset currently applied to the clock path |
| holdover | output | 1 | Holdover request to the clock path |
| div_rst | output | 1 | One-cycle reset for the output and feedback dividers |
| busy | output | 1 | Start-bit readback; high while the sequence runs |

## Verification
The internal state can go wrong in a few ways, and each one shows at the ports:

- **Bad step counter.** The offset jumps by more than one step, or two steps come closer together than the tick spacing. This shows at the very next offset change.
- **Out-of-order sequence.** `div_rst` fires with a non-zero offset or outside holdover. Alternatively, the sequence gives two pulses or none. This shows within the sequence itself.
- **Lost target latch.** `busy` falls while the applied offset differs from the target. This shows in the cycle holdover drops.

A start that is queued or restarted when it should have been ignored shows as `busy` rising again without a request, a few cycles after completion.

// File: rtl/phofs_pkg.sv
package phofs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_DOWN,
        ST_DRST,
        ST_UP
    } seq_state_t;

    typedef enum logic [1:0] {
        GOAL_TARGET,
        GOAL_ZERO,
        GOAL_FREEZE
    } goal_sel_t;

    typedef struct packed {
        logic      hold;
        logic      drst;
        logic      busy;
        goal_sel_t goal;
    } seq_ctrl_t;

    function automatic seq_ctrl_t decode_state(seq_state_t s);
        seq_ctrl_t c;
        c.hold = (s != ST_IDLE);
        c.busy = (s != ST_IDLE);
        c.drst = (s == ST_DRST);
        case (s)
            ST_IDLE: c.goal = GOAL_TARGET;
            ST_DOWN: c.goal = GOAL_ZERO;
            ST_UP:   c.goal = GOAL_TARGET;
            default: c.goal = GOAL_FREEZE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/phofs_ramp.sv
module phofs_ramp #(
    parameter int W        = 12,
    parameter int STEP     = 4,
    parameter int STEP_DIV = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] goal,
    input  logic                freeze,
    output logic signed [W-1:0] applied,
    output logic                at_goal
);
    localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [CW-1:0] TICK_LAST = CW'(STEP_DIV - 1);
    localparam logic signed [W:0] STEP_P = (W+1)'(STEP);
    localparam logic signed [W:0] STEP_N = -STEP_P;

    logic [CW-1:0]       tick;
    logic signed [W:0]   diff;
    logic signed [W:0]   delta;
    logic signed [W:0]   nxt;

    assign diff    = {goal[W-1], goal} - {applied[W-1], applied};
    assign at_goal = (diff == '0);

    always_comb begin
        if (diff > STEP_P)       delta = STEP_P;
        else if (diff < STEP_N)  delta = STEP_N;
        else                     delta = diff;
        nxt = {applied[W-1], applied} + delta;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            applied <= '0;
            tick    <= '0;
        end else if (freeze || at_goal) begin
            tick    <= '0;
        end else if (tick == TICK_LAST) begin
            tick    <= '0;
            applied <= nxt[W-1:0];
        end else begin
            tick    <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/phofs_ctrl.sv
module phofs_ctrl
    import phofs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cal_req,
    input  logic      at_goal,
    output seq_ctrl_t ctrl
);
    seq_state_t state, state_n;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE: if (cal_req) state_n = ST_HOLD;
            ST_HOLD: state_n = ST_DOWN;
            ST_DOWN: if (at_goal) state_n = ST_DRST;
            ST_DRST: state_n = ST_UP;
            ST_UP:   if (at_goal) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    assign ctrl = decode_state(state);
endmodule

// File: rtl/phofs_recal_seq.sv
module phofs_recal_seq
    import phofs_pkg::*;
#(
    parameter int OFS_W    = 12,
    parameter int STEP     = 4,
    parameter int STEP_DIV = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cal_req,
    input  logic signed [OFS_W-1:0] target_ofs,
    output logic signed [OFS_W-1:0] applied_ofs,
    output logic                    holdover,
    output logic                    div_rst,
    output logic                    busy
);
    seq_ctrl_t                 ctrl;
    logic signed [OFS_W-1:0]   tgt_q;
    logic signed [OFS_W-1:0]   goal;
    logic                      at_goal;

    always_ff @(posedge clk) begin
        if (rst) tgt_q <= '0;
        else     tgt_q <= target_ofs;
    end

    always_comb begin
        case (ctrl.goal)
            GOAL_ZERO: goal = '0;
            GOAL_TARGET: goal = tgt_q;
            default:   goal = applied_ofs;
        endcase
    end

    phofs_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cal_req (cal_req),
        .at_goal (at_goal),
        .ctrl    (ctrl)
    );

    phofs_ramp #(
        .W        (OFS_W),
        .STEP     (STEP),
        .STEP_DIV (STEP_DIV)
    ) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .goal    (goal),
        .freeze  (ctrl.goal == GOAL_FREEZE),
        .applied (applied_ofs),
        .at_goal (at_goal)
    );

    assign holdover = ctrl.hold;
    assign div_rst  = ctrl.drst;
    assign busy     = ctrl.busy;
endmodule

// File: rtl/phofs_recal_chk.sv
module phofs_recal_chk #(
    parameter int W    = 12,
    parameter int STEP = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cal_req,
    input logic                busy,
    input logic                holdover,
    input logic                div_rst,
    input logic signed [W-1:0] applied_ofs,
    input logic signed [W-1:0] tgt_q
);
    logic signed [W-1:0] prev_q;
    logic signed [W:0]   dlt;
    logic signed [W:0]   mag;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= applied_ofs;
    end

    assign dlt = {applied_ofs[W-1], applied_ofs} - {prev_q[W-1], prev_q};
    assign mag = (dlt < 0) ? -dlt : dlt;

    p_step_bound_r2: assert property (@(posedge clk) disable iff (rst)
        mag <= (W+1)'(STEP));

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (cal_req && !busy) |=> (busy && holdover));

    p_divrst_zero_r4: assert property (@(posedge clk) disable iff (rst)
        div_rst |-> (applied_ofs == '0 && holdover));

    p_divrst_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        div_rst |=> !div_rst);

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (applied_ofs == $past(tgt_q) && !holdover));
endmodule

bind phofs_recal_seq phofs_recal_chk #(.W(OFS_W), .STEP(STEP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cal_req     (cal_req),
    .busy        (busy),
    .holdover    (holdover),
    .div_rst     (div_rst),
    .applied_ofs (applied_ofs),
    .tgt_q       (tgt_q)
);

// File: tb/phofs_recal_seq_bench.sv
module phofs_recal_seq_bench;
    localparam int CLK_P = 10;
    localparam int W     = 12;
    localparam int STEP  = 4;
    localparam int SDIV  = 3;
    localparam int NVEC  = 6;
    localparam logic signed [W-1:0] VEC [NVEC] =
        '{12'sd40, -12'sd23, 12'sd0, 12'sd2047, -12'sd2048, 12'sd5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cal_req = 1'b0;
    logic signed [W-1:0] target_ofs = '0;
    logic signed [W-1:0] applied_ofs;
    logic holdover, div_rst, busy;

    int n_chk = 0;
    int n_fail = 0;
    int step_viol = 0;
    int gap_viol = 0;

    always #(CLK_P/2) clk = ~clk;

    phofs_recal_seq #(.OFS_W(W), .STEP(STEP), .STEP_DIV(SDIV)) u_phofs_recal_seq (
        .clk(clk), .rst(rst), .cal_req(cal_req), .target_ofs(target_ofs),
        .applied_ofs(applied_ofs), .holdover(holdover), .div_rst(div_rst), .busy(busy)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 monitor: step size and spacing of every offset change
    initial begin
        int last;
        int gap;
        last = 0;
        gap = 1000;
        forever begin
            @(negedge clk);
            if (rst) begin
                last = 0;
                gap = 1000;
            end else begin
                gap++;
                if (int'(applied_ofs) != last) begin
                    if (iabs(int'(applied_ofs) - last) > STEP) step_viol++;
                    if (gap < SDIV) gap_viol++;
                    gap = 0;
                    last = int'(applied_ofs);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic check_reset(string tag);
        check(applied_ofs == 0, tag, int'(applied_ofs), 0);
        check(!holdover && !div_rst && !busy, tag,
              int'({holdover, div_rst, busy}), 0);
    endtask

    task automatic run_cal(logic signed [W-1:0] new_tgt, bit change, bit rereq, string tag);
        int drst;
        int zero_bad;
        int hold_bad;
        int rise_bad;
        int cyc;
        int mprev;
        drst = 0;
        zero_bad = 0;
        hold_bad = 0;
        rise_bad = 0;
        cyc = 0;
        @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        check(busy && holdover, {"R3 ", tag}, int'({busy, holdover}), 3);
        mprev = iabs(int'(applied_ofs));
        while (busy && cyc < 20000) begin
            if (cyc == 2 && change) target_ofs = new_tgt;
            cal_req = (cyc == 4 && rereq);
            if (div_rst) begin
                drst++;
                if (applied_ofs != 0) zero_bad++;
            end
            if (!holdover) hold_bad++;
            if (drst == 0) begin
                if (iabs(int'(applied_ofs)) > mprev) rise_bad++;
                mprev = iabs(int'(applied_ofs));
            end
            @(negedge clk);
            cyc++;
        end
        cal_req = 1'b0;
        check(zero_bad == 0 && rise_bad == 0 && hold_bad == 0, {"R4 ", tag},
              zero_bad + rise_bad + hold_bad, 0);
        check(drst == 1, {"R5 ", tag}, drst, 1);
        check(!busy && !holdover, {"R6 ", tag}, int'({busy, holdover}), 0);
        check(applied_ofs == target_ofs, change ? {"R7 ", tag} : {"R6 ", tag},
              int'(applied_ofs), int'(target_ofs));
        if (rereq) begin
            repeat (10) @(negedge clk);
            check(!busy && !holdover, {"R8 ", tag}, int'({busy, holdover}), 0);
        end
    endtask

    initial begin
        int cur;
        cur = 0;
        repeat (3) @(negedge clk);
        check_reset("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        check_reset("R1 after reset");

        // R2: idle ramps toward a table of targets
        for (int i = 0; i < NVEC; i++) begin
            int wt;
            target_ofs = VEC[i];
            wt = ((iabs(int'(VEC[i]) - cur) + STEP - 1) / STEP) * SDIV + 4;
            repeat (wt) @(negedge clk);
            check(applied_ofs == VEC[i], "R2 idle ramp", int'(applied_ofs), int'(VEC[i]));
            check(!busy && !holdover, "R2 no holdover", int'({busy, holdover}), 0);
            cur = int'(VEC[i]);
        end

        run_cal(12'sd5, 1'b0, 1'b0, "small");
        target_ofs = 12'sd300;
        repeat (240) @(negedge clk);
        run_cal(12'sd300, 1'b0, 1'b0, "plain");
        run_cal(-12'sd100, 1'b1, 1'b0, "retarget");
        run_cal(-12'sd100, 1'b0, 1'b1, "rereq");
        target_ofs = 12'sd0;
        repeat (100) @(negedge clk);
        run_cal(12'sd0, 1'b0, 1'b0, "at zero");

        check(step_viol == 0, "R2 step size", step_viol, 0);
        check(gap_viol == 0, "R2 step spacing", gap_viol, 0);

        // R1: reset in mid-sequence
        target_ofs = 12'sd200;
        repeat (200) @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset("R1 mid-sequence");
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule